// File: doc/BRIEF.md
# Cascadable programmable interrupt controller

This block collects eight interrupt request lines, lets software block any of them, picks the most urgent one under a fixed priority order and raises a single interrupt output to the processor. When the processor acknowledges, the winning line is recorded as in service and an 8-bit vector is returned. The vector is a programmable base, aligned to eight, plus the line number. Software ends the service of a line with a specific end-of-interrupt command that names its level. A separate trigger-select register makes each line edge- or level-sensitive.

Two copies can be chained. One copy is strapped as master and the other as slave, with the slave's interrupt output feeding one of the master's inputs. When the master's winning line has a slave behind it, the master returns no vector. It publishes the line number on a 3-bit cascade bus instead. The slave whose programmed identity matches that number answers the following acknowledge with its own vector. Software then ends service on the slave for the slave's line, and on the master for the cascade line.

Before use, the block is programmed with a four-word setup sequence through a byte-wide port that has one address bit and a trigger-register select. Acknowledge is a one-cycle strobe. All outputs are registered, and the vector and cascade results appear in the cycle after the strobe.

Top module: `cpic_ctrl`

## Requirements
- R1: A command write (addr 0, trig_sel 0) with bit 4 and bit 0 set is setup word 1. It clears the mask, request and in-service registers and restarts setup. The next three data writes (addr 1) are words 2, 3 and 4, in that order. int_out stays low until word 4 has been written. Out of reset the mask reads 0xFF. After word 1 it reads 0x00.
- R2: A command write with bit 4 set and bit 0 clear is ignored. Setup is not restarted and the mask is kept.
- R3: Word 2 bits [7:3] form the vector base. Acknowledging a winning line n that has no slave behind it gives vec_valid=1 and vec_out = base*8 + n in the next cycle.
- R4: After setup, a data write (addr 1) sets the mask and a data read returns it. A mask bit of 1 keeps its line out of priority resolution, so 0xFF blocks all eight lines. Requests on masked lines are still recorded.
- R5: Priority is fixed, with line 0 highest. int_out is high only when the best unmasked request has a lower line number than every in-service level. Each acknowledge adds at most one in-service bit.
- R6: A command write with bits [7:5]=011 and bits [4:3]=00 is a specific end-of-interrupt. It clears only the in-service bit named by bits [2:0]. Naming a level that is not in service changes nothing.
- R7: The trigger-select register is written and read with trig_sel=1, and a 1 bit makes its line level-sensitive. In edge mode a rising input sets the request and acknowledge clears it. In level mode the request follows the input. In both modes the request drops when the input goes low.
- R8: On a master (role_master=1), a winning line whose bit is set in word 3 acknowledges with cas_drive=1, cas_out = line number and vec_valid=0.
- R9: A slave (role_master=0) takes its identity from word 3 bits [2:0]. It answers an acknowledge only when cas_in equals that identity, and otherwise ignores the acknowledge.
- R10: An acknowledge with no winning request returns vec_valid=1 with vector base*8+7 and leaves the in-service register unchanged.
- R11: A command write with bits [7:4]=0000, bit 3=1 and bit 1=1 selects what a command read (addr 0) returns: the request register if bit 0=0, the in-service register if bit 0=1. Word 1 resets the selection to the request register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| role_master | input | 1 | 1 = master, 0 = slave |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | 0 = command, 1 = data/mask |
| trig_sel | input | 1 | Selects the trigger-select register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| irq_in | input | 8 | Interrupt request lines |
| ack | input | 1 | One-cycle acknowledge strobe |
| cas_in | input | 3 | Cascade line number seen by a slave |
| int_out | output | 1 | Interrupt to processor |
| vec_out | output | 8 | Vector |
| vec_valid | output | 1 | Vector present (one cycle) |
| cas_out | output | 3 | Cascade line number driven by a master |
| cas_drive | output | 1 | Master drives cascade number (one cycle) |

## Verification
The assertions check on every cycle that an acknowledge adds at most one in-service bit and never one for a line that was masked. They also check that setup word 1 empties the in-service and mask registers, that an end-of-interrupt clears its named level, that every vector carries the programmed base, that a vector and a cascade number never appear together, and that a slave answers only its own identity. The bench scenarios are what show the priority ordering among several live requests and the difference between edge and level triggering after an end-of-interrupt. They also cover the spurious vector, the ignored malformed setup word, and the complete two-copy cascade handshake, where the slave vector follows the master's cascade number.

// File: rtl/cpic_pkg.sv
package cpic_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_W2,
    ST_W3,
    ST_W4,
    ST_RUN
  } setup_st_t;

  localparam logic [2:0] CMD_SEOI = 3'b011;
endpackage

// File: rtl/cpic_regs.sv
module cpic_regs
  import cpic_pkg::*;
#(
  parameter int NL = 8,
  localparam int IW = $clog2(NL),
  localparam int BW = 8 - IW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          addr,
  input  logic          trig_sel,
  input  logic [7:0]    wdata,
  output logic [NL-1:0] mask,
  output logic [NL-1:0] trig,
  output logic [BW-1:0] base,
  output logic [NL-1:0] cas_map,
  output logic [IW-1:0] cas_id,
  output logic          ready,
  output logic          init_clr,
  output logic          eoi_en,
  output logic [IW-1:0] eoi_lvl,
  output logic          rd_isr_sel
);
  setup_st_t st;
  logic wr_cmd, wr_dat, wr_trg, is_rsel;

  always_comb begin
    wr_cmd   = wr_en && !trig_sel && !addr;
    wr_dat   = wr_en && !trig_sel && addr;
    wr_trg   = wr_en && trig_sel;
    init_clr = wr_cmd && wdata[4] && wdata[0];
    eoi_en   = wr_cmd && ready && (wdata[4:3] == 2'b00) && (wdata[7:5] == CMD_SEOI);
    is_rsel  = wr_cmd && ready && (wdata[7:4] == 4'h0) && wdata[3] && wdata[1];
    eoi_lvl  = wdata[IW-1:0];
    ready    = (st == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_OFF;
      mask       <= '1;
      trig       <= '0;
      base       <= '0;
      cas_map    <= '0;
      cas_id     <= '0;
      rd_isr_sel <= 1'b0;
    end else begin
      if (wr_trg) trig <= wdata[NL-1:0];
      if (init_clr) begin
        st         <= ST_W2;
        mask       <= '0;
        rd_isr_sel <= 1'b0;
      end else begin
        if (wr_dat) begin
          case (st)
            ST_W2: begin
              base <= wdata[7:IW];
              st   <= ST_W3;
            end
            ST_W3: begin
              cas_map <= wdata[NL-1:0];
              cas_id  <= wdata[IW-1:0];
              st      <= ST_W4;
            end
            ST_W4:   st   <= ST_RUN;
            ST_RUN:  mask <= wdata[NL-1:0];
            default: st   <= st;
          endcase
        end
        if (is_rsel) rd_isr_sel <= wdata[0];
      end
    end
  end
endmodule

// File: rtl/cpic_req.sv
module cpic_req #(
  parameter int NL = 8,
  localparam int IW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NL-1:0] irq_in,
  input  logic [NL-1:0] trig,
  input  logic          clr,
  input  logic          take_en,
  input  logic [IW-1:0] take_idx,
  output logic [NL-1:0] req
);
  logic [NL-1:0] irq_q, nxt;

  always_comb begin
    nxt = irq_in & (trig | req | (irq_in & ~irq_q));
    if (take_en) nxt[take_idx] = 1'b0;
    if (clr) nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= '0;
      req   <= '0;
    end else begin
      irq_q <= irq_in;
      req   <= nxt;
    end
  end
endmodule

// File: rtl/cpic_core.sv
module cpic_core #(
  parameter int NL = 8,
  localparam int IW = $clog2(NL),
  localparam int BW = 8 - IW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NL-1:0] req,
  input  logic [NL-1:0] mask,
  input  logic          ready,
  input  logic          init_clr,
  input  logic          eoi_en,
  input  logic [IW-1:0] eoi_lvl,
  input  logic          ack,
  input  logic          role_master,
  input  logic [IW-1:0] cas_in,
  input  logic [IW-1:0] cas_id,
  input  logic [NL-1:0] cas_map,
  input  logic [BW-1:0] base,
  output logic [NL-1:0] isr,
  output logic          int_out,
  output logic [7:0]    vec_out,
  output logic          vec_valid,
  output logic [IW-1:0] cas_out,
  output logic          cas_drive,
  output logic          take_en,
  output logic [IW-1:0] take_idx
);
  function automatic logic [IW:0] first_set(input logic [NL-1:0] v);
    logic [IW:0] r;
    r = '0;
    for (int i = NL - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, IW'(i)};
    end
    return r;
  endfunction

  logic [IW:0]   p_f, s_f;
  logic          win, acc;
  logic [NL-1:0] isr_nxt;

  always_comb begin
    p_f      = first_set(req & ~mask);
    s_f      = first_set(isr);
    win      = ready && p_f[IW] && (!s_f[IW] || (p_f[IW-1:0] < s_f[IW-1:0]));
    acc      = ack && ready && (role_master || (cas_in == cas_id));
    take_en  = acc && win;
    take_idx = p_f[IW-1:0];
    isr_nxt  = isr;
    if (take_en) isr_nxt[take_idx] = 1'b1;
    if (eoi_en) isr_nxt[eoi_lvl] = 1'b0;
    if (init_clr) isr_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr       <= '0;
      int_out   <= 1'b0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
      cas_out   <= '0;
      cas_drive <= 1'b0;
    end else begin
      isr       <= isr_nxt;
      int_out   <= win;
      vec_valid <= 1'b0;
      cas_drive <= 1'b0;
      if (acc) begin
        if (win && role_master && cas_map[take_idx]) begin
          cas_drive <= 1'b1;
          cas_out   <= take_idx;
        end else if (win) begin
          vec_out   <= {base, take_idx};
          vec_valid <= 1'b1;
        end else begin
          vec_out   <= {base, {IW{1'b1}}};
          vec_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cpic_ctrl.sv
module cpic_ctrl #(
  parameter int NLINES = 8,
  localparam int IDW = $clog2(NLINES),
  localparam int BSW = 8 - IDW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              role_master,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic              trig_sel,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [NLINES-1:0] irq_in,
  input  logic              ack,
  input  logic [IDW-1:0]    cas_in,
  output logic              int_out,
  output logic [7:0]        vec_out,
  output logic              vec_valid,
  output logic [IDW-1:0]    cas_out,
  output logic              cas_drive
);
  logic [NLINES-1:0] mask_q, trig_q, cmap_q, req_q, isr_q;
  logic [BSW-1:0]    base_q;
  logic [IDW-1:0]    cas_id_q, eoi_lvl, take_idx;
  logic              ready_q, init_clr, eoi_en, rd_isr_sel, take_en;

  cpic_regs #(.NL(NLINES)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .trig_sel(trig_sel),
    .wdata(wdata), .mask(mask_q), .trig(trig_q), .base(base_q),
    .cas_map(cmap_q), .cas_id(cas_id_q), .ready(ready_q),
    .init_clr(init_clr), .eoi_en(eoi_en), .eoi_lvl(eoi_lvl),
    .rd_isr_sel(rd_isr_sel)
  );

  cpic_req #(.NL(NLINES)) u_req (
    .clk(clk), .rst(rst), .irq_in(irq_in), .trig(trig_q), .clr(init_clr),
    .take_en(take_en), .take_idx(take_idx), .req(req_q)
  );

  cpic_core #(.NL(NLINES)) u_core (
    .clk(clk), .rst(rst), .req(req_q), .mask(mask_q), .ready(ready_q),
    .init_clr(init_clr), .eoi_en(eoi_en), .eoi_lvl(eoi_lvl), .ack(ack),
    .role_master(role_master), .cas_in(cas_in), .cas_id(cas_id_q),
    .cas_map(cmap_q), .base(base_q), .isr(isr_q), .int_out(int_out),
    .vec_out(vec_out), .vec_valid(vec_valid), .cas_out(cas_out),
    .cas_drive(cas_drive), .take_en(take_en), .take_idx(take_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (trig_sel)        rdata <= 8'(trig_q);
      else if (addr)       rdata <= 8'(mask_q);
      else if (rd_isr_sel) rdata <= 8'(isr_q);
      else                 rdata <= 8'(req_q);
    end
  end
endmodule

// File: rtl/cpic_ctrl_chk.sv
module cpic_ctrl_chk #(
  parameter int NLINES = 8,
  localparam int IDW = $clog2(NLINES),
  localparam int BSW = 8 - IDW
) (
  input logic              clk,
  input logic              rst,
  input logic              role_master,
  input logic              wr_en,
  input logic              addr,
  input logic              trig_sel,
  input logic [7:0]        wdata,
  input logic              ack,
  input logic [IDW-1:0]    cas_in,
  input logic              int_out,
  input logic [7:0]        vec_out,
  input logic              vec_valid,
  input logic              cas_drive,
  input logic [NLINES-1:0] isr,
  input logic [NLINES-1:0] mask,
  input logic [BSW-1:0]    base,
  input logic [IDW-1:0]    cas_id,
  input logic              ready
);
  p_init_clear_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !trig_sel && !addr && wdata[4] && wdata[0]) |=> (isr == '0 && mask == '0));

  p_no_int_setup_r1: assert property (@(posedge clk) disable iff (rst)
    int_out |-> $past(ready));

  p_vec_base_r3: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (vec_out[7:IDW] == base));

  p_masked_r4: assert property (@(posedge clk) disable iff (rst)
    (isr & ~$past(isr) & $past(mask)) == '0);

  p_one_entry_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(isr & ~$past(isr)) <= 1);

  p_eoi_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ready && !trig_sel && !addr && wdata[7:5] == 3'b011 && wdata[4:3] == 2'b00)
      |=> !isr[$past(wdata[IDW-1:0])]);

  p_cas_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(vec_valid && cas_drive));

  p_slave_sel_r9: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && !role_master) |-> ($past(ack) && $past(cas_in) == cas_id));
endmodule

bind cpic_ctrl cpic_ctrl_chk #(.NLINES(NLINES)) u_chk (
  .clk(clk), .rst(rst), .role_master(role_master), .wr_en(wr_en),
  .addr(addr), .trig_sel(trig_sel), .wdata(wdata), .ack(ack),
  .cas_in(cas_in), .int_out(int_out), .vec_out(vec_out),
  .vec_valid(vec_valid), .cas_drive(cas_drive), .isr(isr_q),
  .mask(mask_q), .base(base_q), .cas_id(cas_id_q), .ready(ready_q)
);

// File: tb/cpic_ctrl_test.sv
module cpic_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_wr = 0, s_wr = 0, rd = 0, addr = 0, tsel = 0;
  logic [7:0] wdata = 0;
  logic [7:0] m_irq = 0, s_irq = 0;
  logic m_ack = 0, s_ack = 0;
  logic [2:0] s_cas = 0;
  logic [7:0] m_rdata, s_rdata, m_vec, s_vec;
  logic m_int, s_int, m_vv, s_vv, m_cd, s_cd;
  logic [2:0] m_co, s_co;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cpic_ctrl uut (
    .clk(clk), .rst(rst), .role_master(1'b1), .wr_en(m_wr), .rd_en(rd),
    .addr(addr), .trig_sel(tsel), .wdata(wdata), .rdata(m_rdata),
    .irq_in({m_irq[7:3], s_int, m_irq[1:0]}), .ack(m_ack), .cas_in(3'd0),
    .int_out(m_int), .vec_out(m_vec), .vec_valid(m_vv), .cas_out(m_co),
    .cas_drive(m_cd)
  );

  cpic_ctrl uut_s (
    .clk(clk), .rst(rst), .role_master(1'b0), .wr_en(s_wr), .rd_en(rd),
    .addr(addr), .trig_sel(tsel), .wdata(wdata), .rdata(s_rdata),
    .irq_in(s_irq), .ack(s_ack), .cas_in(s_cas),
    .int_out(s_int), .vec_out(s_vec), .vec_valid(s_vv), .cas_out(s_co),
    .cas_drive(s_cd)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic to_s, input logic a, input logic ts, input logic [7:0] d);
    @(negedge clk);
    addr = a; tsel = ts; wdata = d; m_wr = !to_s; s_wr = to_s;
    @(negedge clk);
    m_wr = 0; s_wr = 0; tsel = 0;
  endtask

  task automatic rdreg(input logic to_s, input logic a, input logic ts, output logic [7:0] q);
    @(negedge clk);
    addr = a; tsel = ts; rd = 1;
    @(negedge clk);
    rd = 0; tsel = 0;
    q = to_s ? s_rdata : m_rdata;
  endtask

  task automatic setup(input logic to_s, input logic [7:0] b, input logic [7:0] w3);
    wr(to_s, 0, 0, 8'h11);
    wr(to_s, 1, 0, b);
    wr(to_s, 1, 0, w3);
    wr(to_s, 1, 0, 8'h01);
  endtask

  task automatic read_isr(input logic to_s, output logic [7:0] q);
    wr(to_s, 0, 0, 8'h0B);
    rdreg(to_s, 0, 0, q);
  endtask

  task automatic read_req(input logic to_s, output logic [7:0] q);
    wr(to_s, 0, 0, 8'h0A);
    rdreg(to_s, 0, 0, q);
  endtask

  task automatic mack(output logic vv, output logic [7:0] v, output logic cd, output logic [2:0] co);
    @(negedge clk); m_ack = 1;
    @(negedge clk); m_ack = 0;
    vv = m_vv; v = m_vec; cd = m_cd; co = m_co;
  endtask

  task automatic sack(input logic [2:0] id, output logic vv, output logic [7:0] v);
    @(negedge clk); s_ack = 1; s_cas = id;
    @(negedge clk); s_ack = 0;
    vv = s_vv; v = s_vec;
  endtask

  task automatic t_reset();
    logic [7:0] q;
    chk("R1 int after reset", {7'd0, m_int}, 8'h00);
    chk("R1 vec_valid after reset", {7'd0, m_vv}, 8'h00);
    rdreg(0, 1, 0, q);
    chk("R1 mask after reset", q, 8'hFF);
  endtask

  task automatic t_init();
    logic [7:0] q, v; logic vv, cd; logic [2:0] co;
    wr(0, 0, 0, 8'h11);
    wr(0, 1, 0, 8'h20);
    m_irq[0] = 1;
    idle(3);
    chk("R1 int low mid-setup", {7'd0, m_int}, 8'h00);
    wr(0, 1, 0, 8'h00);
    wr(0, 1, 0, 8'h01);
    idle(3);
    chk("R1 int after setup", {7'd0, m_int}, 8'h01);
    rdreg(0, 1, 0, q);
    chk("R1 mask after word1", q, 8'h00);
    mack(vv, v, cd, co);
    chk("R3 vec_valid", {7'd0, vv}, 8'h01);
    chk("R3 vector line0", v, 8'h20);
    m_irq[0] = 0;
    wr(0, 0, 0, 8'h60);
    read_isr(0, q);
    chk("R6 isr after eoi0", q, 8'h00);
  endtask

  task automatic t_priority();
    logic [7:0] q, v; logic vv, cd; logic [2:0] co;
    m_irq[6] = 1; m_irq[3] = 1;
    idle(3);
    mack(vv, v, cd, co);
    chk("R5 winner of 3,6", v, 8'h23);
    idle(3);
    chk("R5 line6 blocked by isr3", {7'd0, m_int}, 8'h00);
    wr(0, 0, 0, 8'h65);
    read_isr(0, q);
    chk("R6 eoi of idle level harmless", q, 8'h08);
    m_irq[1] = 1;
    idle(3);
    chk("R5 line1 outranks isr3", {7'd0, m_int}, 8'h01);
    mack(vv, v, cd, co);
    chk("R5 nested vector", v, 8'h21);
    wr(0, 0, 0, 8'h61);
    idle(3);
    chk("R5 still blocked by isr3", {7'd0, m_int}, 8'h00);
    wr(0, 0, 0, 8'h63);
    idle(3);
    chk("R5 line6 after eoi3", {7'd0, m_int}, 8'h01);
    mack(vv, v, cd, co);
    chk("R5 vector line6", v, 8'h26);
    wr(0, 0, 0, 8'h66);
    m_irq[1] = 0; m_irq[3] = 0; m_irq[6] = 0;
    read_isr(0, q);
    chk("R11 isr readback empty", q, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] q, v; logic vv, cd; logic [2:0] co;
    wr(0, 1, 0, 8'hFF);
    rdreg(0, 1, 0, q);
    chk("R4 mask readback", q, 8'hFF);
    m_irq[4] = 1;
    idle(3);
    chk("R4 all masked int low", {7'd0, m_int}, 8'h00);
    read_req(0, q);
    chk("R11 request readback masked line", q, 8'h10);
    wr(0, 1, 0, 8'hEF);
    idle(3);
    chk("R4 unmasked int high", {7'd0, m_int}, 8'h01);
    mack(vv, v, cd, co);
    chk("R4 vector line4", v, 8'h24);
    wr(0, 0, 0, 8'h64);
    m_irq[4] = 0;
    wr(0, 1, 0, 8'h00);
  endtask

  task automatic t_trigger();
    logic [7:0] q, v; logic vv, cd; logic [2:0] co;
    m_irq[5] = 1;
    idle(1);
    m_irq[5] = 0;
    idle(3);
    chk("R7 edge request dropped", {7'd0, m_int}, 8'h00);
    read_req(0, q);
    chk("R7 request cleared", q, 8'h00);
    wr(0, 0, 1, 8'h20);
    rdreg(0, 0, 1, q);
    chk("R7 trigger readback", q, 8'h20);
    m_irq[5] = 1;
    idle(3);
    mack(vv, v, cd, co);
    chk("R7 level vector", v, 8'h25);
    wr(0, 0, 0, 8'h65);
    idle(3);
    chk("R7 level retriggers", {7'd0, m_int}, 8'h01);
    m_irq[5] = 0;
    idle(3);
    chk("R7 level drops", {7'd0, m_int}, 8'h00);
    wr(0, 0, 1, 8'h00);
    m_irq[6] = 1;
    idle(3);
    mack(vv, v, cd, co);
    wr(0, 0, 0, 8'h66);
    idle(3);
    chk("R7 edge no retrigger", {7'd0, m_int}, 8'h00);
    m_irq[6] = 0;
  endtask

  task automatic t_spurious();
    logic [7:0] q, v; logic vv, cd; logic [2:0] co;
    idle(2);
    mack(vv, v, cd, co);
    chk("R10 spurious valid", {7'd0, vv}, 8'h01);
    chk("R10 spurious vector", v, 8'h27);
    read_isr(0, q);
    chk("R10 isr unchanged", q, 8'h00);
  endtask

  task automatic t_bad_word1();
    logic [7:0] q;
    wr(0, 1, 0, 8'h55);
    wr(0, 0, 0, 8'h10);
    rdreg(0, 1, 0, q);
    chk("R2 mask kept", q, 8'h55);
    wr(0, 1, 0, 8'h00);
  endtask

  task automatic t_reinit();
    logic [7:0] q, v; logic vv, cd; logic [2:0] co;
    m_irq[0] = 1;
    idle(3);
    mack(vv, v, cd, co);
    m_irq[0] = 0;
    wr(0, 1, 0, 8'h80);
    wr(0, 0, 0, 8'h11);
    rdreg(0, 1, 0, q);
    chk("R1 reinit mask cleared", q, 8'h00);
    wr(0, 1, 0, 8'h30);
    wr(0, 1, 0, 8'h00);
    wr(0, 1, 0, 8'h01);
    read_isr(0, q);
    chk("R1 reinit isr cleared", q, 8'h00);
    m_irq[1] = 1;
    idle(3);
    mack(vv, v, cd, co);
    chk("R3 new base vector", v, 8'h31);
    wr(0, 0, 0, 8'h61);
    m_irq[1] = 0;
  endtask

  task automatic t_cascade();
    logic [7:0] q, v; logic vv, cd; logic [2:0] co;
    setup(0, 8'h20, 8'h04);
    setup(1, 8'h28, 8'h02);
    s_irq[3] = 1;
    idle(6);
    chk("R8 master int via slave", {7'd0, m_int}, 8'h01);
    sack(3'd5, vv, v);
    chk("R9 slave ignores other id", {7'd0, vv}, 8'h00);
    chk("R9 slave int held", {7'd0, s_int}, 8'h01);
    mack(vv, v, cd, co);
    chk("R8 cascade drive", {7'd0, cd}, 8'h01);
    chk("R8 cascade number", {5'd0, co}, 8'h02);
    chk("R8 no master vector", {7'd0, vv}, 8'h00);
    sack(co, vv, v);
    chk("R9 slave vector valid", {7'd0, vv}, 8'h01);
    chk("R9 slave vector", v, 8'h2B);
    s_irq[3] = 0;
    wr(1, 0, 0, 8'h63);
    wr(0, 0, 0, 8'h62);
    read_isr(1, q);
    chk("R6 slave isr cleared", q, 8'h00);
    read_isr(0, q);
    chk("R6 master isr cleared", q, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rst = 0;
    idle(1);
    t_reset();
    t_init();
    t_priority();
    t_mask();
    t_trigger();
    t_spurious();
    t_bad_word1();
    t_reinit();
    t_cascade();
    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule